// File: doc/BRIEF.md
# Iterative Carry-Less Divider

This block divides one unsigned polynomial over GF(2) by another and returns the quotient and the remainder. Every operand and result has the same width `W`. Because the arithmetic is carry-less, each reduction step uses an XOR of the aligned divisor in place of a subtraction, so no carry or borrow ever moves between bit positions.

The datapath is iterative and handles one operation at a time. After the block accepts an operand pair, it forms one quotient bit per step, from the most significant bit down, for `W` steps in total. A compile-time parameter `STEPS` sets how many of these steps are chained into each clock cycle. A higher value gives lower latency at the cost of a longer combinational path. Operands enter through a valid/ready handshake, and results leave through a second valid/ready handshake. A result stays held until the consumer takes it.

Top module: `gf2_divider`

## Requirements
- R1: For a nonzero divisor, the outputs satisfy dividend = clmul(quotient, divisor) XOR remainder, and the degree of the remainder is below the degree of the divisor. The result for a zero divisor is unspecified.
- R2: After a cycle with `rst` high at a clock edge, `in_ready` is 1 and `out_valid` is 0.
- R3: While idle, `in_ready` is 1 and `out_valid` is 0. `in_ready` and `out_valid` are never high together.
- R4: An operand pair is accepted at a clock edge where `in_valid` and `in_ready` are both 1. After that edge, `in_ready` and `out_valid` stay 0 for exactly ceil(W/STEPS) cycles. `out_valid` rises at the ceil(W/STEPS)-th edge after the accepting edge.
- R5: Changes to `dividend`, `divisor` or `in_valid` while an operation is in flight have no effect on the result.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `quotient` and `remainder` hold their values and `in_ready` stays 0.
- R7: At a clock edge with `out_valid` and `out_ready` both 1, the block returns to idle. In the next cycle `out_valid` is 0 and `in_ready` is 1.
- R8: When the degree of the dividend is below the degree of the divisor, the quotient is 0 and the remainder equals the dividend.
- R9: A divisor of 1 gives quotient = dividend and remainder = 0. The all-ones dividend divided by a divisor that has only the top bit set gives quotient 1 and a remainder equal to the lower W-1 bits of the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to accept operands |
| dividend | input | W | Polynomial to be divided |
| divisor | input | W | Polynomial to divide by |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| quotient | output | W | Carry-less quotient |
| remainder | output | W | Carry-less remainder |

## Verification
The handshake flags are due one clock edge after the event that changes them, with one exception: `out_valid` rises exactly ceil(W/STEPS) edges after the accepting edge. The quotient and remainder have to be correct from that cycle on and must not change until the output handshake completes. The bench keeps a behavioural model of the phases (idle, computing, holding). The model advances on each rising edge from the same input values the design sees. The bench compares the flags and results against the model at every falling edge, so each expected change is checked in the first cycle it is due. While an operation is in flight, the bench drives random junk operands with `in_valid` high. This shows that the result is unaffected and that no second operation is accepted.

// File: rtl/gf2div_pkg.sv
package gf2div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HOLD = 2'd2
  } div_phase_e;
endpackage

// File: rtl/gf2div_lead.sv
// Position of the highest set bit of a vector (0 when the vector is zero).
module gf2div_lead #(
  parameter int W = 8,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/gf2div_step.sv
// One reduction step: decides one quotient bit and XORs the aligned divisor.
module gf2div_step #(
  parameter int W     = 8,
  parameter int CNT_W = 5,
  localparam int PW   = $clog2(W)
) (
  input  logic [W-1:0]     rem_i,
  input  logic [W-1:0]     quo_i,
  input  logic [W-1:0]     dsr,
  input  logic [PW-1:0]    dsr_msb,
  input  logic [CNT_W-1:0] step_idx,
  output logic [W-1:0]     rem_o,
  output logic [W-1:0]     quo_o
);
  logic [CNT_W-1:0] qbit;
  logic [CNT_W-1:0] tpos;
  logic [W-1:0]     probe;
  logic             take;

  always_comb begin
    qbit  = CNT_W'(W - 1) - step_idx;
    tpos  = qbit + CNT_W'(dsr_msb);
    probe = rem_i >> tpos;
    take  = (step_idx < CNT_W'(W)) && (tpos < CNT_W'(W)) && probe[0];
    rem_o = rem_i;
    quo_o = quo_i;
    if (take) begin
      rem_o = rem_i ^ (dsr << qbit);
      quo_o = quo_i | (W'(1) << qbit);
    end
  end
endmodule

// File: rtl/gf2div_ctrl.sv
// Phase sequencer and step counter.
module gf2div_ctrl
  import gf2div_pkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             advance,
  output logic [CNT_W-1:0] step_base
);
  div_phase_e phase;
  logic       last_pass;

  assign in_ready  = (phase == PH_IDLE);
  assign out_valid = (phase == PH_HOLD);
  assign load      = in_ready && in_valid;
  assign advance   = (phase == PH_RUN);
  assign last_pass = (step_base + CNT_W'(STEPS)) >= CNT_W'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      step_base <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (in_valid) begin
          phase     <= PH_RUN;
          step_base <= '0;
        end
        PH_RUN: begin
          step_base <= step_base + CNT_W'(STEPS);
          if (last_pass) phase <= PH_HOLD;
        end
        PH_HOLD: if (out_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2_divider.sv
module gf2_divider #(
  parameter int W     = 8,
  parameter int STEPS = 3,
  localparam int PW    = $clog2(W),
  localparam int CNT_W = $clog2(W + STEPS) + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic             load, advance;
  logic [CNT_W-1:0] step_base;
  logic [W-1:0]     dsr_q;
  logic [PW-1:0]    msb_q, msb_in;
  logic [W-1:0]     rem_q, quo_q;
  logic [W-1:0]     rem_c [STEPS+1];
  logic [W-1:0]     quo_c [STEPS+1];

  gf2div_ctrl #(.W(W), .STEPS(STEPS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load),
    .advance(advance), .step_base(step_base)
  );

  gf2div_lead #(.W(W)) u_lead (.vec(divisor), .pos(msb_in));

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    gf2div_step #(.W(W), .CNT_W(CNT_W)) u_step (
      .rem_i(rem_c[k]), .quo_i(quo_c[k]), .dsr(dsr_q), .dsr_msb(msb_q),
      .step_idx(step_base + CNT_W'(k)),
      .rem_o(rem_c[k+1]), .quo_o(quo_c[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      msb_q <= '0;
    end else if (load) begin
      rem_q <= dividend;
      quo_q <= '0;
      dsr_q <= divisor;
      msb_q <= msb_in;
    end else if (advance) begin
      rem_q <= rem_c[STEPS];
      quo_q <= quo_c[STEPS];
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/gf2_divider_chk.sv
module gf2_divider_chk #(
  parameter int W     = 8,
  parameter int STEPS = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int LAT = (W + STEPS - 1) / STEPS;
  localparam int LW  = $clog2(LAT + 1) + 1;

  logic [LW-1:0] busy_cnt;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) busy_cnt <= '0;
    else if (in_valid && in_ready) busy_cnt <= LW'(LAT);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  always @(negedge clk) begin
    if (rst_q) begin
      p_reset_idle_r2: assert (in_ready && !out_valid)
        else $error("R2 reset state");
    end
  end

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0) |-> (!in_ready && !out_valid));

  p_valid_on_time_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(busy_cnt) == LW'(1)));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && !in_ready &&
      $stable(quotient) && $stable(remainder)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind gf2_divider gf2_divider_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/test_gf2_divider.sv
module test_gf2_divider;
  localparam int W     = 8;
  localparam int STEPS = 3;
  localparam int LAT   = (W + STEPS - 1) / STEPS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] quotient, remainder;

  int compared = 0;
  int mismatched = 0;

  gf2_divider #(.W(W), .STEPS(STEPS)) i_gf2_divider (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .out_valid(out_valid),
    .out_ready(out_ready), .quotient(quotient), .remainder(remainder)
  );

  always #5 clk = ~clk;

  // Behavioural reference: polynomial long division by degree.
  function automatic int degree(input int v);
    int d = -1;
    for (int i = 0; i < 32; i++) if ((v >> i) & 1) d = i;
    return d;
  endfunction

  function automatic void ref_div(input int n, input int d,
                                  output int q, output int r);
    q = 0;
    r = n;
    if (d == 0) return;
    while (degree(r) >= degree(d)) begin
      q = q | (1 << (degree(r) - degree(d)));
      r = r ^ (d << (degree(r) - degree(d)));
    end
  endfunction

  // Phase model: 0 idle, 1 computing, 2 holding.
  int    m_phase = 0, m_prev = 0, m_left = 0;
  int    m_q = 0, m_r = 0, m_d = 0;
  string cur_tag = "R1";

  always @(posedge clk) begin
    m_prev <= m_phase;
    if (rst) begin
      m_phase <= 0;
    end else begin
      case (m_phase)
        0: if (in_valid) begin
          int q, r;
          ref_div(int'(dividend), int'(divisor), q, r);
          m_q <= q; m_r <= r; m_d <= int'(divisor);
          m_phase <= 1; m_left <= LAT;
        end
        1: begin
          m_left <= m_left - 1;
          if (m_left == 1) m_phase <= 2;
        end
        default: if (out_ready) m_phase <= 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      if (m_phase == 0) tag = (m_prev == 2) ? "R7" : "R3";
      else if (m_phase == 1) tag = "R4";
      else tag = "R6";
      check({tag, " in_ready"}, int'(in_ready), int'(m_phase == 0));
      check({tag, " out_valid"}, int'(out_valid), int'(m_phase == 2));
      if (m_phase == 2 && m_d != 0) begin
        check({cur_tag, " quotient"}, int'(quotient), m_q);
        check({cur_tag, " remainder"}, int'(remainder), m_r);
      end
    end
  end

  // Junk with in_valid high while busy (R5); hold result for some cycles (R6).
  task automatic run_op(input int n, input int d, input string tag, input int hold);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_tag   = tag;
    dividend  = W'(n);
    divisor   = W'(d);
    in_valid  = 1'b1;
    @(negedge clk);
    while (!out_valid) begin
      dividend = W'($urandom);
      divisor  = W'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int i = 0; i < hold; i++) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2 in_ready", int'(in_ready), 1);
    check("R2 out_valid", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    run_op(8'h05, 8'h10, "R8", 0);
    run_op(8'h03, 8'h07, "R8", 1);
    run_op(8'hB7, 8'h01, "R9", 2);
    run_op(8'hFF, 8'h80, "R9", 0);
    run_op(8'h00, 8'h35, "R1/R5", 0);
    run_op(8'hFF, 8'hFF, "R1/R5", 3);
    run_op(8'h80, 8'h03, "R1/R5", 1);
    for (int i = 0; i < 300; i++) begin
      int dd = int'($urandom_range(1, (1 << W) - 1));
      run_op(int'($urandom_range(0, (1 << W) - 1)), dd, "R1/R5", i % 4);
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R2 in_ready after reset", int'(in_ready), 1);
    check("R2 out_valid after reset", int'(out_valid), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule